// File: doc/BRIEF.md
# Byte-Matrix Vector Register File

This block holds a square grid of byte cells, 64 rows by 64 columns, and lets a vector unit treat it as a set of 16-lane vectors. An access picks a lane width (byte, halfword or word), a direction (along a row, so the column advances, or down a column, so the row advances) and a starting coordinate. It then touches 16 lanes of consecutive cells from that point. A multi-byte lane fills consecutive cells along the access direction, least significant byte first. Both coordinates wrap around the grid edge.

An optional packed offset operand adds a row displacement and a column displacement to the start point. Without the offset, the start coordinate along the access direction has to sit on a boundary set by the lane width. A start that breaks this rule raises an error flag, and a write that carries it is dropped. With the offset, any start point is legal.

Writes come in on a valid/ready port. Ready is low only while a clear sweep is running. While ready is low, the source must hold its write; the block neither stores it nor drops it. A write offered while ready is high is taken on that clock edge. If that write carries an error, it is consumed and discarded. Reads are combinational and have no handshake. The clear sweep zeroes one row per cycle. Soft reset returns the sweep control to idle and leaves stored bytes untouched.

Top module: `vrf_matrix`

## Requirements
- R1: A vector carries 16 lanes. Lane i sits in bus bits [32i+31:32i]. Bits above the selected lane width read as zero.
- R2: Width code 0 selects byte lanes, 1 selects halfword lanes and 2 selects word lanes. A lane of W bytes fills W consecutive cells along the access direction, lowest byte in the lowest cell. Vector byte b = lane*W + k sits at start + b.
- R3: Direction 0 holds the row fixed and advances the column. Direction 1 holds the column fixed and advances the row. All coordinate sums wrap modulo 64.
- R4: When the offset is enabled, offset bits [11:6] are added to the row and bits [5:0] to the column, modulo 64, before the access.
- R5: In row mode without offset, byte lanes need a column that is a multiple of 16.
- R6: In row mode without offset, halfword lanes need a column of 0 or 32.
- R7: In row mode without offset, word lanes need column 0.
- R8: In column mode, the rules of R5 to R7 apply to the row instead of the column, and the column is free.
- R9: With the offset enabled, no alignment error is raised for width codes 0 to 2.
- R10: Width code 3 always flags an error and reads as all zero. An erroneous write that is accepted changes no cell.
- R11: Clear request taken while idle starts a 64-cycle sweep that zeroes rows 0 to 63, one per cycle. wr_ready is low throughout, and writes offered then are not stored. A write accepted in the same cycle as the request is stored and is then cleared by the sweep.
- R12: Soft reset forces the sweep idle and wr_ready high, and keeps all stored bytes.
- R13: An accepted write shows on the read port from the next cycle on. In its own cycle, the read port still shows the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous soft reset of control state |
| clr_req | input | 1 | Request a full clear sweep |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_wsel | input | 2 | Write lane width code |
| wr_dir | input | 1 | Write direction (0 row, 1 column) |
| wr_row | input | 6 | Write start row |
| wr_col | input | 6 | Write start column |
| wr_off_en | input | 1 | Add packed offset to write address |
| wr_off | input | 12 | Packed write offset (row in [11:6], column in [5:0]) |
| wr_data | input | 512 | Write vector, 16 lanes of 32 bits |
| wr_err | output | 1 | Write address breaks a rule |
| rd_wsel | input | 2 | Read lane width code |
| rd_dir | input | 1 | Read direction |
| rd_row | input | 6 | Read start row |
| rd_col | input | 6 | Read start column |
| rd_off_en | input | 1 | Add packed offset to read address |
| rd_off | input | 12 | Packed read offset |
| rd_data | output | 512 | Read vector |
| rd_err | output | 1 | Read address breaks a rule |

## Verification
Two collisions matter. The first is a write and a read aimed at the same cells in one cycle: the read must still return the old bytes, and the new bytes must appear one cycle later. The second is a write offered in the same cycle as a clear request: the write is stored and is then wiped by the sweep. A behavioural model in the bench holds its own byte grid and sweep state. The bench drives these collisions directly, then mixes random traffic with occasional clear requests and compares every output against the model on each clock.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2,
    LW_NONE = 2'd3
  } lane_w_e;
endpackage

// File: rtl/vrf_addr_unit.sv
module vrf_addr_unit
  import vrf_pkg::*;
#(
  parameter int CW    = 6,
  parameter int LANES = 16
) (
  input  logic [1:0]      wsel,
  input  logic            dir,
  input  logic [CW-1:0]   row,
  input  logic [CW-1:0]   col,
  input  logic            off_en,
  input  logic [2*CW-1:0] off,
  output logic [CW-1:0]   base_row,
  output logic [CW-1:0]   base_col,
  output logic            err
);
  localparam int SW = CW + 3;

  logic [SW-1:0] span;
  logic [SW-1:0] coord;
  logic          misaligned;

  // span of one vector in cells along the access direction
  assign span       = SW'(LANES) << wsel;
  assign coord      = SW'(dir ? row : col);
  assign misaligned = (coord & (span - SW'(1))) != '0;
  assign err        = (lane_w_e'(wsel) == LW_NONE) | (~off_en & misaligned);

  assign base_row = row + (off_en ? off[2*CW-1:CW] : '0);
  assign base_col = col + (off_en ? off[CW-1:0] : '0);
endmodule

// File: rtl/vrf_clear_seq.sv
module vrf_clear_seq #(
  parameter int ROWS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic [$clog2(ROWS)-1:0] row_idx
);
  localparam int RW = $clog2(ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      row_idx <= '0;
    end else if (busy) begin
      if (row_idx == RW'(ROWS - 1)) busy <= 1'b0;
      row_idx <= row_idx + RW'(1);
    end else if (start) begin
      busy    <= 1'b1;
      row_idx <= '0;
    end
  end
endmodule

// File: rtl/vrf_matrix.sv
module vrf_matrix
  import vrf_pkg::*;
#(
  parameter int GRID      = 64,
  parameter int LANES     = 16,
  parameter int LANE_BITS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_req,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [1:0]                    wr_wsel,
  input  logic                          wr_dir,
  input  logic [$clog2(GRID)-1:0]       wr_row,
  input  logic [$clog2(GRID)-1:0]       wr_col,
  input  logic                          wr_off_en,
  input  logic [2*$clog2(GRID)-1:0]     wr_off,
  input  logic [LANES*LANE_BITS-1:0]    wr_data,
  output logic                          wr_err,
  input  logic [1:0]                    rd_wsel,
  input  logic                          rd_dir,
  input  logic [$clog2(GRID)-1:0]       rd_row,
  input  logic [$clog2(GRID)-1:0]       rd_col,
  input  logic                          rd_off_en,
  input  logic [2*$clog2(GRID)-1:0]     rd_off,
  output logic [LANES*LANE_BITS-1:0]    rd_data,
  output logic                          rd_err
);
  localparam int CW   = $clog2(GRID);
  localparam int LB   = LANE_BITS / 8;
  localparam int MAXB = LANES * LB;
  localparam int IW   = $clog2(MAXB);
  localparam int RB   = GRID * 8;

  // storage: packed rows of bytes, deliberately not reset
  logic [GRID-1:0][RB-1:0] grid_q;
  logic [GRID-1:0][RB-1:0] grid_nxt;

  logic [CW-1:0] rd_brow, rd_bcol, wr_brow, wr_bcol;
  logic          clr_busy;
  logic [CW-1:0] clr_row;
  logic          wr_fire;

  logic [CW-1:0] r_row [MAXB];
  logic [CW-1:0] r_col [MAXB];
  logic [CW-1:0] w_row [MAXB];
  logic [CW-1:0] w_col [MAXB];
  logic [7:0]    rbyte [MAXB];
  logic [7:0]    wbyte [MAXB];

  vrf_addr_unit #(.CW(CW), .LANES(LANES)) u_rd_addr (
    .wsel(rd_wsel), .dir(rd_dir), .row(rd_row), .col(rd_col),
    .off_en(rd_off_en), .off(rd_off),
    .base_row(rd_brow), .base_col(rd_bcol), .err(rd_err)
  );

  vrf_addr_unit #(.CW(CW), .LANES(LANES)) u_wr_addr (
    .wsel(wr_wsel), .dir(wr_dir), .row(wr_row), .col(wr_col),
    .off_en(wr_off_en), .off(wr_off),
    .base_row(wr_brow), .base_col(wr_bcol), .err(wr_err)
  );

  vrf_clear_seq #(.ROWS(GRID)) u_clr (
    .clk(clk), .rst_n(rst_n), .start(clr_req),
    .busy(clr_busy), .row_idx(clr_row)
  );

  assign wr_ready = ~clr_busy;
  assign wr_fire  = wr_valid & wr_ready & ~wr_err;

  // cell coordinates of every vector byte, wrapping at the grid edge
  for (genvar b = 0; b < MAXB; b++) begin : g_cell
    assign r_row[b] = rd_dir ? rd_brow + CW'(b) : rd_brow;
    assign r_col[b] = rd_dir ? rd_bcol : rd_bcol + CW'(b);
    assign w_row[b] = wr_dir ? wr_brow + CW'(b) : wr_brow;
    assign w_col[b] = wr_dir ? wr_bcol : wr_bcol + CW'(b);
    assign rbyte[b] = grid_q[r_row[b]][{r_col[b], 3'b000} +: 8];
  end

  // read: gather bytes into lanes, zero above the lane width
  always_comb begin
    rd_data = '0;
    if (lane_w_e'(rd_wsel) != LW_NONE) begin
      for (int l = 0; l < LANES; l++) begin
        for (int k = 0; k < LB; k++) begin
          if (k < (1 << rd_wsel))
            rd_data[l*LANE_BITS + k*8 +: 8] = rbyte[IW'((l << rd_wsel) + k)];
        end
      end
    end
  end

  // write: split lanes into vector bytes
  always_comb begin
    for (int b = 0; b < MAXB; b++) begin
      if ((b >> wr_wsel) < LANES)
        wbyte[b] = wr_data[(b >> wr_wsel)*LANE_BITS + (b & ((1 << wr_wsel) - 1))*8 +: 8];
      else
        wbyte[b] = '0;
    end
  end

  always_comb begin
    grid_nxt = grid_q;
    if (clr_busy) grid_nxt[clr_row] = '0;
    if (wr_fire) begin
      for (int b = 0; b < MAXB; b++) begin
        if (b < (LANES << wr_wsel))
          grid_nxt[w_row[b]][{w_col[b], 3'b000} +: 8] = wbyte[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    grid_q <= grid_nxt;
  end
endmodule

// File: rtl/vrf_matrix_chk.sv
module vrf_matrix_chk #(
  parameter int GRID = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clr_req,
  input logic                        wr_ready,
  input logic [1:0]                  wr_wsel,
  input logic                        wr_dir,
  input logic [$clog2(GRID)-1:0]     wr_row,
  input logic [$clog2(GRID)-1:0]     wr_col,
  input logic                        wr_off_en,
  input logic                        wr_err
);
  logic [15:0] sweep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sweep_cnt <= '0;
    else if (wr_ready) sweep_cnt <= '0;
    else               sweep_cnt <= sweep_cnt + 16'd1;
  end

  AST_CLR_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && wr_ready) |=> !wr_ready); // R11

  AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ready) |-> (sweep_cnt == 16'(GRID))); // R11

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> wr_ready); // R12

  AST_OFFSET_NO_ALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off_en && wr_wsel != 2'd3) |-> !wr_err); // R9

  AST_BYTE_ROW_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_off_en && wr_wsel == 2'd0 && !wr_dir && wr_col[3:0] != 4'd0) |-> wr_err); // R5

  AST_WORD_COL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_off_en && wr_wsel == 2'd2 && wr_dir && wr_row != '0) |-> wr_err); // R8

  AST_WIDTH3_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wsel == 2'd3) |-> wr_err); // R10
endmodule

bind vrf_matrix vrf_matrix_chk #(.GRID(GRID)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .wr_ready(wr_ready),
  .wr_wsel(wr_wsel), .wr_dir(wr_dir), .wr_row(wr_row), .wr_col(wr_col),
  .wr_off_en(wr_off_en), .wr_err(wr_err)
);

// File: tb/tb_vrf_matrix.sv
`timescale 1ns/1ps
module tb_vrf_matrix;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0, clr_req = 1'b0, wr_valid = 1'b0;
  logic         wr_ready, wr_err, rd_err;
  logic [1:0]   wr_wsel = '0, rd_wsel = '0;
  logic         wr_dir = 1'b0, rd_dir = 1'b0, wr_off_en = 1'b0, rd_off_en = 1'b0;
  logic [5:0]   wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
  logic [11:0]  wr_off = '0, rd_off = '0;
  logic [511:0] wr_data = '0, rd_data;

  vrf_matrix dut (.*);

  int    checks = 0, fails = 0;
  string phase = "init";
  bit    known = 0, done = 0;
  byte unsigned mem [64][64];
  bit    mbusy = 0;
  int    mrow = 0;

  function automatic bit exp_err(logic [1:0] ws, logic d, logic [5:0] r, logic [5:0] c, logic oe);
    int span, coord;
    if (ws == 2'd3) return 1'b1;
    if (oe) return 1'b0;
    span  = 16 << ws;
    coord = d ? int'(r) : int'(c);
    return (coord % span) != 0;
  endfunction

  function automatic logic [511:0] exp_rd();
    logic [511:0] v = '0;
    int w, br, bc, b, r, c;
    if (rd_wsel == 2'd3) return v;
    w  = 1 << rd_wsel;
    br = (int'(rd_row) + (rd_off_en ? int'(rd_off[11:6]) : 0)) % 64;
    bc = (int'(rd_col) + (rd_off_en ? int'(rd_off[5:0]) : 0)) % 64;
    for (int l = 0; l < 16; l++)
      for (int k = 0; k < w; k++) begin
        b = l * w + k;
        r = rd_dir ? (br + b) % 64 : br;
        c = rd_dir ? bc : (bc + b) % 64;
        v[l*32 + k*8 +: 8] = mem[r][c];
      end
    return v;
  endfunction

  // behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    int w, br, bc, r, c;
    if (!rst_n) mbusy = 0;
    else if (mbusy) begin
      for (int j = 0; j < 64; j++) mem[mrow][j] = 8'h00;
      if (mrow == 63) begin mbusy = 0; known = 1; end
      else mrow++;
    end else begin
      if (wr_valid && !exp_err(wr_wsel, wr_dir, wr_row, wr_col, wr_off_en)) begin
        w  = 1 << wr_wsel;
        br = (int'(wr_row) + (wr_off_en ? int'(wr_off[11:6]) : 0)) % 64;
        bc = (int'(wr_col) + (wr_off_en ? int'(wr_off[5:0]) : 0)) % 64;
        for (int b = 0; b < 16 * w; b++) begin
          r = wr_dir ? (br + b) % 64 : br;
          c = wr_dir ? bc : (bc + b) % 64;
          mem[r][c] = wr_data[(b / w)*32 + (b % w)*8 +: 8];
        end
      end
      if (clr_req) begin mbusy = 1; mrow = 0; end
    end
  end

  task automatic chk(bit ok, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    logic [511:0] e;
    bit ew, er;
    #3;
    ew = exp_err(wr_wsel, wr_dir, wr_row, wr_col, wr_off_en);
    er = exp_err(rd_wsel, rd_dir, rd_row, rd_col, rd_off_en);
    chk(wr_ready == !mbusy, "wr_ready", 512'(wr_ready), 512'(!mbusy));
    chk(wr_err == ew, "wr_err", 512'(wr_err), 512'(ew));
    chk(rd_err == er, "rd_err", 512'(rd_err), 512'(er));
    if (known) begin
      e = exp_rd();
      chk(rd_data === e, "rd_data", rd_data, e);
    end
  end

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_wr(bit v, logic [1:0] ws, logic d, logic [5:0] r, logic [5:0] c,
                        logic oe, logic [11:0] o);
    wr_valid = v; wr_wsel = ws; wr_dir = d; wr_row = r; wr_col = c;
    wr_off_en = oe; wr_off = o; wr_data = rnd512();
  endtask

  task automatic mirror_rd();
    rd_wsel = wr_wsel; rd_dir = wr_dir; rd_row = wr_row; rd_col = wr_col;
    rd_off_en = wr_off_en; rd_off = wr_off;
  endtask

  task automatic rand_access(bit aligned, bit use_off);
    logic [1:0] ws = 2'($urandom % 3);
    logic d = 1'($urandom);
    int span = 16 << ws;
    logic [5:0] r = 6'($urandom), c = 6'($urandom);
    if (aligned) begin
      if (d) r = 6'(($urandom % (64 / span)) * span);
      else   c = 6'(($urandom % (64 / span)) * span);
    end
    set_wr(1'($urandom), ws, d, r, c, use_off, 12'($urandom));
    if ($urandom % 2) mirror_rd();
    else begin
      rd_wsel = 2'($urandom % 3); rd_dir = 1'($urandom);
      rd_row = 6'($urandom); rd_col = 6'($urandom);
      rd_off_en = use_off; rd_off = 12'($urandom);
    end
  endtask

  initial begin
    tick(3);
    phase = "R12 reset state";
    rst_n = 1'b1;
    tick(2);

    phase = "R11 clear sweep";
    clr_req = 1'b1; tick(); clr_req = 1'b0;
    set_wr(1, 2'd0, 1'b0, 6'd0, 6'd0, 1'b0, '0);
    tick(70);
    wr_valid = 1'b0; tick();

    phase = "R13 read after write";
    set_wr(1, 2'd1, 1'b0, 6'd5, 6'd32, 1'b0, '0); mirror_rd();
    tick(); wr_valid = 1'b0; tick(2);

    phase = "R1 R2 R3 lanes and direction";
    for (int i = 0; i < 300; i++) begin rand_access(1, 0); tick(); end

    phase = "R4 offset wrap";
    for (int i = 0; i < 300; i++) begin rand_access(0, 1); tick(); end

    phase = "R5 byte alignment";
    set_wr(1, 2'd0, 1'b0, 6'd9, 6'd5, 1'b0, '0); mirror_rd(); tick();
    set_wr(1, 2'd0, 1'b0, 6'd9, 6'd48, 1'b0, '0); mirror_rd(); tick();
    phase = "R6 halfword alignment";
    set_wr(1, 2'd1, 1'b0, 6'd3, 6'd16, 1'b0, '0); mirror_rd(); tick();
    set_wr(1, 2'd1, 1'b0, 6'd3, 6'd32, 1'b0, '0); mirror_rd(); tick();
    phase = "R7 word alignment";
    set_wr(1, 2'd2, 1'b0, 6'd7, 6'd32, 1'b0, '0); mirror_rd(); tick();
    set_wr(1, 2'd2, 1'b0, 6'd7, 6'd0, 1'b0, '0); mirror_rd(); tick();
    phase = "R8 column mode alignment";
    set_wr(1, 2'd2, 1'b1, 6'd16, 6'd0, 1'b0, '0); mirror_rd(); tick();
    set_wr(1, 2'd0, 1'b1, 6'd17, 6'd3, 1'b0, '0); mirror_rd(); tick();
    set_wr(1, 2'd0, 1'b1, 6'd32, 6'd5, 1'b0, '0); mirror_rd(); tick();
    phase = "R9 offset overrides alignment";
    set_wr(1, 2'd2, 1'b0, 6'd1, 6'd13, 1'b1, 12'h000); mirror_rd(); tick();
    set_wr(1, 2'd1, 1'b1, 6'd7, 6'd2, 1'b1, 12'hFC1); mirror_rd(); tick();
    phase = "R10 suppressed write";
    set_wr(1, 2'd1, 1'b0, 6'd7, 6'd8, 1'b0, '0); mirror_rd(); tick();
    wr_valid = 1'b0; rd_col = 6'd0; tick();
    set_wr(1, 2'd3, 1'b0, 6'd0, 6'd0, 1'b1, '0); mirror_rd(); tick();
    wr_valid = 1'b0; rd_wsel = 2'd0; tick();

    phase = "R11 write with clear request";
    set_wr(1, 2'd0, 1'b0, 6'd0, 6'd0, 1'b0, '0); mirror_rd();
    clr_req = 1'b1; tick(); clr_req = 1'b0;
    set_wr(1, 2'd2, 1'b1, 6'd0, 6'd9, 1'b0, '0); mirror_rd();
    tick(68);
    wr_valid = 1'b0; tick();

    phase = "R12 soft reset keeps data";
    set_wr(1, 2'd2, 1'b0, 6'd20, 6'd0, 1'b0, '0); mirror_rd(); tick();
    wr_valid = 1'b0; tick();
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);

    phase = "R1 R4 R9 R10 R11 mixed traffic";
    for (int i = 0; i < 1500; i++) begin
      rand_access($urandom % 2, $urandom % 2);
      clr_req = (($urandom % 300) == 0);
      tick();
    end
    clr_req = 1'b0; wr_valid = 1'b0; tick(70);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule